// File: doc/BRIEF.md
# Fault-Injectable Two-Input Gate Emulator

This block is a cycle-based model of one two-input CMOS logic gate, NAND or NOR, chosen per vector, into which a single fault can be injected. Each valid cycle takes one test vector on two inputs. It produces three results: what a healthy gate would output, what the damaged gate outputs, and whether the two differ. A test-generation or teaching environment can use it to find out which vectors and vector pairs expose which defects.

Nine faults are available. Six are the classic stuck-at faults on either input or the output. Three are transistor opens in a NOR gate. An open is modelled as the output node keeping its previous logic value for the input rows that would have needed the missing transistor. Such a fault therefore needs a two-vector sequence before it shows.

Alongside the per-vector results, the block keeps a sticky bitmap of which fault codes have been exposed. It also keeps a collapsed coverage figure: the number of equivalence classes of the current gate type that contain at least one exposed stuck-at fault.

Top module: `fault_gate_emu`

## Requirements
- R1: After synchronous reset, res_valid, good_out, bad_out, detect, cov_map and class_cnt are all 0.
- R2: A vector applied with vec_valid=1 gives res_valid=1 on the next cycle. On that cycle good_out is NAND(a,b) when gate_sel=0 and NOR(a,b) when gate_sel=1.
- R3: Fault codes: 1 = input a stuck-at-0, 2 = a stuck-at-1, 3 = b stuck-at-0, 4 = b stuck-at-1, 5 = output stuck-at-0, 6 = output stuck-at-1. bad_out shows the gate evaluated with that fault.
- R4: detect is 1 exactly when the registered bad_out differs from good_out for a valid vector. A cycle with vec_valid=0 gives res_valid=0 and detect=0, and changes neither the outputs nor the coverage.
- R5: With gate_sel=1 (NOR), three codes make the output keep its previous faulty value on one input row each: code 7 on a=1,b=0; code 8 on a=0,b=1; code 9 on a=0,b=0. All other rows give the normal NOR result.
- R6: The previous faulty value used by R5 is 0 after reset. Only valid vectors update it.
- R7: Codes 7 to 9 under NAND, and codes 0 and 10 to 15 under either gate, behave as fault-free (bad_out equals good_out).
- R8: cov_map bit k-1 becomes 1 on the cycle that a vector under code k (1 to 9) is detected, and stays 1.
- R9: clr_cov=1 zeroes cov_map on the next cycle. The clear wins over a detection in the same cycle.
- R10: class_cnt counts the covered classes of the gate type of the most recent valid vector. A class is covered when any of its member codes is set in cov_map. The NAND classes are {1,3,6}, {2,5} and {4,5}. The NOR classes are {2,4,5}, {1,6} and {3,6}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_cov | input | 1 | Synchronous clear of the coverage bitmap |
| vec_valid | input | 1 | A test vector is present this cycle |
| gate_sel | input | 1 | 0 = NAND, 1 = NOR |
| fault_sel | input | 4 | Injected fault code (0 = none) |
| in_a | input | 1 | Vector input a |
| in_b | input | 1 | Vector input b |
| res_valid | output | 1 | Results below belong to last cycle's vector |
| good_out | output | 1 | Fault-free gate output |
| bad_out | output | 1 | Faulty gate output, also the retained value |
| detect | output | 1 | good_out and bad_out differ |
| cov_map | output | 9 | Sticky detected-fault bitmap, bit k-1 for code k |
| class_cnt | output | 2 | Number of covered equivalence classes |

## Verification
The stimulus walks several two-vector sequences for each transistor open. Some sequences initialise the retained node to the wrong value, so a design that ignored the retained state, or that refreshed it on idle cycles, would report detections that a real open could not give. The stimulus also shows that a stuck-at-1 on an input of a NAND is exposed only by the single row that holds that input at 0. It also shows that open codes are ignored under NAND.

For coverage, the bench checks that switching gate type changes the collapsed count even when the bitmap stays the same, since a design using a fixed class table would miss that. A clear that arrives together with a detection must leave the map empty.

// File: rtl/fge_pkg.sv
package fge_pkg;
  localparam int FGE_CODE_W = 4;
  localparam int FGE_NUM_FAULTS = 9;
  localparam int FGE_NUM_CLASSES = 3;

  localparam logic GATE_NAND = 1'b0;
  localparam logic GATE_NOR  = 1'b1;

  localparam logic [FGE_CODE_W-1:0] F_NONE     = 4'd0;
  localparam logic [FGE_CODE_W-1:0] F_A_SA0    = 4'd1;
  localparam logic [FGE_CODE_W-1:0] F_A_SA1    = 4'd2;
  localparam logic [FGE_CODE_W-1:0] F_B_SA0    = 4'd3;
  localparam logic [FGE_CODE_W-1:0] F_B_SA1    = 4'd4;
  localparam logic [FGE_CODE_W-1:0] F_Y_SA0    = 4'd5;
  localparam logic [FGE_CODE_W-1:0] F_Y_SA1    = 4'd6;
  localparam logic [FGE_CODE_W-1:0] F_OPEN_DNA = 4'd7;
  localparam logic [FGE_CODE_W-1:0] F_OPEN_DNB = 4'd8;
  localparam logic [FGE_CODE_W-1:0] F_OPEN_UP  = 4'd9;
endpackage

// File: rtl/fge_fault_model.sv
module fge_fault_model
  import fge_pkg::*;
(
  input  logic                  gate_sel,
  input  logic [FGE_CODE_W-1:0] code,
  input  logic                  a,
  input  logic                  b,
  input  logic                  held,
  output logic                  good,
  output logic                  bad
);
  logic ea, eb, core;
  logic keep;

  assign good = (gate_sel == GATE_NOR) ? ~(a | b) : ~(a & b);

  always_comb begin
    ea = a;
    eb = b;
    if (code == F_A_SA0) ea = 1'b0;
    if (code == F_A_SA1) ea = 1'b1;
    if (code == F_B_SA0) eb = 1'b0;
    if (code == F_B_SA1) eb = 1'b1;
    core = (gate_sel == GATE_NOR) ? ~(ea | eb) : ~(ea & eb);
  end

  always_comb begin
    keep = 1'b0;
    if (gate_sel == GATE_NOR) begin
      unique case (code)
        F_OPEN_DNA: keep =  a & ~b;
        F_OPEN_DNB: keep = ~a &  b;
        F_OPEN_UP:  keep = ~a & ~b;
        default:    keep = 1'b0;
      endcase
    end
  end

  always_comb begin
    bad = core;
    if (code == F_Y_SA0) bad = 1'b0;
    if (code == F_Y_SA1) bad = 1'b1;
    if (keep) bad = held;
  end
endmodule

// File: rtl/fge_cov_map.sv
module fge_cov_map #(
  parameter int NUM_FAULTS = 9,
  parameter int CODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  hit,
  input  logic [CODE_W-1:0]     code,
  output logic [NUM_FAULTS-1:0] map
);
  for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_bit
    localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(i + 1);
    always_ff @(posedge clk) begin
      if (rst || clr) map[i] <= 1'b0;
      else if (hit && code == MY_CODE) map[i] <= 1'b1;
    end
  end

  // R8: coverage bits never fall unless cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((map & $past(map)) == $past(map)));
  // R9: clear empties the map on the next cycle
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (map == '0));
endmodule

// File: rtl/fge_class_count.sv
module fge_class_count #(
  parameter int NUM_FAULTS = 9,
  parameter int CNT_W = 2
) (
  input  logic                  gate_sel,
  input  logic [NUM_FAULTS-1:0] map,
  output logic [CNT_W-1:0]      count
);
  import fge_pkg::*;

  function automatic logic [NUM_FAULTS-1:0] bit_of(input logic [FGE_CODE_W-1:0] c);
    return NUM_FAULTS'(1) << (c - 1);
  endfunction

  localparam logic [NUM_FAULTS-1:0] NAND_C0 = bit_of(F_A_SA0) | bit_of(F_B_SA0) | bit_of(F_Y_SA1);
  localparam logic [NUM_FAULTS-1:0] NAND_C1 = bit_of(F_A_SA1) | bit_of(F_Y_SA0);
  localparam logic [NUM_FAULTS-1:0] NAND_C2 = bit_of(F_B_SA1) | bit_of(F_Y_SA0);
  localparam logic [NUM_FAULTS-1:0] NOR_C0  = bit_of(F_A_SA1) | bit_of(F_B_SA1) | bit_of(F_Y_SA0);
  localparam logic [NUM_FAULTS-1:0] NOR_C1  = bit_of(F_A_SA0) | bit_of(F_Y_SA1);
  localparam logic [NUM_FAULTS-1:0] NOR_C2  = bit_of(F_B_SA0) | bit_of(F_Y_SA1);

  logic [FGE_NUM_CLASSES-1:0] covered;

  always_comb begin
    if (gate_sel == GATE_NOR) begin
      covered[0] = |(map & NOR_C0);
      covered[1] = |(map & NOR_C1);
      covered[2] = |(map & NOR_C2);
    end else begin
      covered[0] = |(map & NAND_C0);
      covered[1] = |(map & NAND_C1);
      covered[2] = |(map & NAND_C2);
    end
  end

  always_comb begin
    count = '0;
    for (int k = 0; k < FGE_NUM_CLASSES; k++) count = count + CNT_W'(covered[k]);
  end
endmodule

// File: rtl/fault_gate_emu.sv
module fault_gate_emu
  import fge_pkg::*;
#(
  parameter int NUM_FAULTS = FGE_NUM_FAULTS,
  parameter int CODE_W = FGE_CODE_W,
  parameter int NUM_CLASSES = FGE_NUM_CLASSES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_cov,
  input  logic                      vec_valid,
  input  logic                      gate_sel,
  input  logic [CODE_W-1:0]         fault_sel,
  input  logic                      in_a,
  input  logic                      in_b,
  output logic                      res_valid,
  output logic                      good_out,
  output logic                      bad_out,
  output logic                      detect,
  output logic [NUM_FAULTS-1:0]     cov_map,
  output logic [$clog2(NUM_CLASSES+1)-1:0] class_cnt
);
  localparam int CNT_W = $clog2(NUM_CLASSES + 1);

  logic good_c, bad_c, hit_c;
  logic gate_q;

  // bad_out doubles as the retained output node used by the open faults
  fge_fault_model i_model (
    .gate_sel (gate_sel),
    .code     (fault_sel),
    .a        (in_a),
    .b        (in_b),
    .held     (bad_out),
    .good     (good_c),
    .bad      (bad_c)
  );

  assign hit_c = vec_valid & (good_c ^ bad_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      detect    <= 1'b0;
      good_out  <= 1'b0;
      bad_out   <= 1'b0;
      gate_q    <= GATE_NAND;
    end else begin
      res_valid <= vec_valid;
      detect    <= hit_c;
      if (vec_valid) begin
        good_out <= good_c;
        bad_out  <= bad_c;
        gate_q   <= gate_sel;
      end
    end
  end

  fge_cov_map #(.NUM_FAULTS(NUM_FAULTS), .CODE_W(CODE_W)) i_cov (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_cov),
    .hit  (hit_c),
    .code (fault_sel),
    .map  (cov_map)
  );

  fge_class_count #(.NUM_FAULTS(NUM_FAULTS), .CNT_W(CNT_W)) i_cls (
    .gate_sel (gate_q),
    .map      (cov_map),
    .count    (class_cnt)
  );

  // R4: a detect always shows a real output difference
  a_r4_detect_differs: assert property (@(posedge clk) disable iff (rst)
    detect |-> (res_valid && good_out != bad_out));
  // R4: idle cycles leave outputs untouched and raise no detect
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |=> (!detect && $stable(bad_out) && $stable(good_out)));
  // R7: no fault selected means no detection
  a_r7_clean_code: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && fault_sel == F_NONE) |=> !detect);
  // R7: open codes are inert on a NAND
  a_r7_open_on_nand: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && gate_sel == GATE_NAND && fault_sel >= F_OPEN_DNA) |=> !detect);
  // R10: empty map gives zero classes
  a_r10_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (cov_map == '0) |-> (class_cnt == '0));
endmodule

// File: tb/test_fault_gate_emu.sv
`timescale 1ns/1ps
module test_fault_gate_emu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_cov = 1'b0, vec_valid = 1'b0, gate_sel = 1'b0, in_a = 1'b0, in_b = 1'b0;
  logic [3:0] fault_sel = 4'd0;
  logic res_valid, good_out, bad_out, detect;
  logic [8:0] cov_map;
  logic [1:0] class_cnt;
  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  fault_gate_emu i_fault_gate_emu (
    .clk(clk), .rst(rst), .clr_cov(clr_cov), .vec_valid(vec_valid),
    .gate_sel(gate_sel), .fault_sel(fault_sel), .in_a(in_a), .in_b(in_b),
    .res_valid(res_valid), .good_out(good_out), .bad_out(bad_out),
    .detect(detect), .cov_map(cov_map), .class_cnt(class_cnt)
  );

  // {gate, code[3:0], a, b, good, bad, det}; retained value tracked row to row
  localparam logic [9:0] TBL [20] = '{
    {1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 NAND clean
    {1'b0, 4'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 a sa1, only exposing row
    {1'b0, 4'd2,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R3
    {1'b0, 4'd2,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R3
    {1'b0, 4'd1,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 a sa0
    {1'b0, 4'd6,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 out sa1
    {1'b0, 4'd7,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R7 open code on NAND
    {1'b1, 4'd7,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 init node to 1
    {1'b1, 4'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R5 retained 1
    {1'b1, 4'd7,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 normal row
    {1'b1, 4'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 wrong init, hidden
    {1'b1, 4'd8,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 hidden
    {1'b1, 4'd8,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 init
    {1'b1, 4'd8,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 exposed
    {1'b1, 4'd9,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 retained 1 = good
    {1'b1, 4'd9,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 init to 0
    {1'b1, 4'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 exposed
    {1'b1, 4'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 out sa0
    {1'b1, 4'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 b sa0
    {1'b1, 4'd12, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}   // R7 unused code
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic clr, input logic g,
                       input logic [3:0] c, input logic a, input logic b);
    @(negedge clk);
    vec_valid = v; clr_cov = clr; gate_sel = g; fault_sel = c; in_a = a; in_b = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 res_valid", 16'(res_valid), 16'd0);
    chk("R1 outputs", {13'd0, good_out, bad_out, detect}, 16'd0);
    chk("R1 cov_map", 16'(cov_map), 16'd0);
    chk("R1 class_cnt", 16'(class_cnt), 16'd0);

    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1'b0, TBL[i][9], TBL[i][8:5], TBL[i][4], TBL[i][3]);
      chk($sformatf("R2 row %0d valid", i), 16'(res_valid), 16'd1);
      chk($sformatf("R2 row %0d good", i), 16'(good_out), 16'(TBL[i][2]));
      chk($sformatf("R3/R5 row %0d bad", i), 16'(bad_out), 16'(TBL[i][1]));
      chk($sformatf("R4 row %0d detect", i), 16'(detect), 16'(TBL[i][0]));
    end
    chk("R8 map after table", 16'(cov_map), 16'h1F7);
    chk("R10 NOR classes", 16'(class_cnt), 16'd3);

    drive(1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
    chk("R9 cleared", 16'(cov_map), 16'd0);
    chk("R4 idle valid", 16'(res_valid), 16'd0);
    chk("R4 idle detect", 16'(detect), 16'd0);
    chk("R10 zero after clear", 16'(class_cnt), 16'd0);

    drive(1'b1, 1'b0, 1'b0, 4'd5, 1'b0, 1'b0);
    chk("R3 NAND out sa0 detect", 16'(detect), 16'd1);
    chk("R8 bit for code 5", 16'(cov_map), 16'h010);
    chk("R10 NAND count", 16'(class_cnt), 16'd2);

    drive(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0);
    chk("R7 clean NOR", {14'd0, good_out, bad_out}, 16'd3);
    chk("R10 NOR count same map", 16'(class_cnt), 16'd1);

    drive(1'b1, 1'b1, 1'b0, 4'd4, 1'b1, 1'b0);
    chk("R3 b sa1 detect", 16'(detect), 16'd1);
    chk("R9 clear beats hit", 16'(cov_map), 16'd0);

    drive(1'b1, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0);
    chk("R8 bit for code 4", 16'(cov_map), 16'h008);
    chk("R10 NAND b sa1 class", 16'(class_cnt), 16'd1);

    drive(1'b1, 1'b0, 1'b1, 4'd9, 1'b1, 1'b1);
    chk("R6 node at 0", 16'(bad_out), 16'd0);
    drive(1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0);
    chk("R4 idle keeps bad", 16'(bad_out), 16'd0);
    chk("R4 idle no detect", 16'(detect), 16'd0);
    chk("R4 idle map", 16'(cov_map), 16'h008);
    drive(1'b1, 1'b0, 1'b1, 4'd9, 1'b0, 1'b0);
    chk("R6 retained through idle", {14'd0, good_out, bad_out}, 16'd2);
    chk("R6 detect", 16'(detect), 16'd1);
    chk("R8 bit for code 9", 16'(cov_map), 16'h108);

    drive(1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule